// File: doc/BRIEF.md
# Tick-Based Clock Source Select and Prescaler

This block runs entirely in one fast reference clock domain and steers the rest of a subsystem with single-cycle clock-enable strobes rather than gated clocks. Six source tick inputs (low-power, low-frequency, real-time, external, phase-locked and a divided low-power source) are chosen through a 3-bit code. The chosen ticks pass through a power-of-two prescaler, and the result is the main bus tick. A second peripheral bus tick is taken from the main bus tick, either as is or on every second pulse. The external source arrives as a raw level, and the block turns it into ticks on both edges or on rising edges only.

Gate registers decide which memory-side and peripheral-side consumers receive the strobes. A busy window follows every accepted change of the clocking setup. During that window the select and divider settings are frozen and no bus ticks are issued. A separate low-power setting chooses which source keeps the core tick alive when the low-power mode input is high, or stops the core tick altogether. Software reaches all settings through a small word-indexed write/read port.

Top module: `tick_ctrl`

## Requirements
- R1: After reset, reads return 0 for the control word (index 0), 0x5 for the memory-side gate word (index 1: bit 0 RAM and bit 2 flash set; bit 1 DMA and bit 3 memory interface clear), 0 for peripheral gate word A (index 2), 0x2 for peripheral gate word B (index 3) and 0 for the low-power word (index 4). All tick and enable outputs are low.
- R2: Control bits 2:0 select the source by code. Code 0 maps to src_i[0], 1 to src_i[1], 2 to src_i[2], 3 to the external level on src_i[3], 5 to src_i[4] and 6 to src_i[5]. Ticks on sources that are not selected produce no bus tick.
- R3: A write that carries code 4 or 7 in a source field leaves the stored selection unchanged. This applies to both the control word and the low-power word.
- R4: Control bits 10:8 hold n, and the main bus tick fires once per 2^n selected source ticks. After the counter restarts, 16·2^n cycles of continuous source ticks yield exactly 16 main ticks.
- R5: With control bit 16 at 0, the peripheral bus tick equals the main bus tick. With bit 16 at 1, it fires on every second main tick, starting with the second one after a restart. The peripheral tick is never high without the main tick.
- R6: Control bit 28 selects the external edge mode. At 0, both edges of src_i[3] make ticks. At 1, only rising edges make ticks.
- R7: A control write that arrives while busy is clear starts a busy window of BUSY_CYCLES cycles. During that window busy_o and control bit 29 read 1, no bus ticks appear, and the prescaler restarts from zero.
- R8: A control write during the busy window leaves the source, main divider and peripheral divider unchanged, but still updates the edge mode bit.
- R9: Each gate-qualified output bit is its gate bit ANDed with its tick. Memory-side enables use the main tick; peripheral enables use the peripheral tick. Bits 28 and 31 of gate word A and bits above 2 of gate word B ignore writes and read 0.
- R10: The low-power word holds a source code in bits 2:0 and an enable in bit 16. While lp_mode_i is high, core_tick_o follows the ticks of that source if the enable is set and stays low if it is clear. While lp_mode_i is low, core_tick_o equals the main bus tick.
- R11: reg_rdata_o presents the word at reg_addr_i one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 6 | Source ticks; bit 3 is the raw external level |
| lp_mode_i | input | 1 | Low-power mode request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| busy_o | output | 1 | Clock switch in progress |
| ahb_tick_o | output | 1 | Main bus tick strobe |
| apb_tick_o | output | 1 | Peripheral bus tick strobe |
| core_tick_o | output | 1 | Core tick strobe |
| ahb_en_o | output | 4 | Gated main-bus enables |
| apb_en0_o | output | 32 | Gated peripheral enables, word A |
| apb_en1_o | output | 3 | Gated peripheral enables, word B |

## Verification
On every cycle, the assertions check that bus ticks stay silent while busy is high, that the peripheral tick never appears without the main tick, and that every gated enable coincides with its tick. They also check that reserved enable bits stay zero, that an accepted control write raises busy, and that a disabled low-power source keeps the core tick low. The exact division ratios and the source-to-code mapping can only be shown by the bench scenarios, which count ticks over windows. The same holds for the two external edge modes, the ignoring of reserved codes and of writes made during the busy window, the length of that window, and the reset read-back values.

// File: rtl/tick_ctrl_pkg.sv
package tick_ctrl_pkg;

  localparam int NUM_SRC  = 6;
  localparam int EXT_IDX  = 3;
  localparam int F_SRC_LO = 0;
  localparam int F_HDIV_LO = 8;
  localparam int F_PDIV   = 16;
  localparam int F_EDGE   = 28;
  localparam int F_BUSY   = 29;
  localparam int F_LPEN   = 16;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_HGATE  = 3'd1,
    RA_PGATEA = 3'd2,
    RA_PGATEB = 3'd3,
    RA_LOWPWR = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic [2:0] src;
    logic [2:0] hdiv;
    logic       pdiv;
    logic       edge_rise;
  } ctrl_cfg_t;

  // codes 4 and 7 carry no source
  function automatic bit src_code_valid(input int code);
    return !(code == 4 || code == 7);
  endfunction

  // position of a code's tick in the packed source vector
  function automatic int code_to_idx(input int code);
    return (code < 4) ? code : code - 1;
  endfunction

endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_ctrl_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 3,
  parameter int          DIV_W       = 3,
  parameter int          HGATE_W     = 4,
  parameter int          PGATE0_W    = 32,
  parameter int          PGATE1_W    = 3,
  parameter int          BUSY_CYCLES = 4,
  parameter logic [3:0]  HGATE_RST   = 4'b0101,
  parameter logic [31:0] PGATE0_MASK = 32'h6FFF_FFFF,
  parameter logic [2:0]  PGATE1_MASK = 3'b111,
  parameter logic [2:0]  PGATE1_RST  = 3'b010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output ctrl_cfg_t           cfg_o,
  output logic [2:0]          lp_src_o,
  output logic                lp_en_o,
  output logic [HGATE_W-1:0]  hgate_o,
  output logic [PGATE0_W-1:0] pgate0_o,
  output logic [PGATE1_W-1:0] pgate1_o,
  output logic                busy_o,
  output logic                restart_o
);

  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

  logic [BCNT_W-1:0] busy_cnt;
  logic              ctrl_wr, ctrl_acc;
  logic              hg_wr, pa_wr, pb_wr, lp_wr;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  assign unused_wdata = &{1'b0, wdata_i};

  assign ctrl_wr  = we_i && (addr_i == ADDR_W'(RA_CTRL));
  assign hg_wr    = we_i && (addr_i == ADDR_W'(RA_HGATE));
  assign pa_wr    = we_i && (addr_i == ADDR_W'(RA_PGATEA));
  assign pb_wr    = we_i && (addr_i == ADDR_W'(RA_PGATEB));
  assign lp_wr    = we_i && (addr_i == ADDR_W'(RA_LOWPWR));
  assign ctrl_acc = ctrl_wr && (busy_cnt == '0);

  assign busy_o    = (busy_cnt != '0);
  assign restart_o = ctrl_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o    <= '0;
      busy_cnt <= '0;
    end else begin
      if (ctrl_acc) begin
        if (src_code_valid(int'(wdata_i[F_SRC_LO +: 3])))
          cfg_o.src <= wdata_i[F_SRC_LO +: 3];
        cfg_o.hdiv <= wdata_i[F_HDIV_LO +: DIV_W];
        cfg_o.pdiv <= wdata_i[F_PDIV];
      end
      if (ctrl_wr)
        cfg_o.edge_rise <= wdata_i[F_EDGE];
      if (ctrl_acc)
        busy_cnt <= BCNT_W'(BUSY_CYCLES);
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hgate_o  <= HGATE_RST;
      pgate0_o <= '0;
      pgate1_o <= PGATE1_RST;
      lp_src_o <= '0;
      lp_en_o  <= 1'b0;
    end else begin
      if (hg_wr) hgate_o  <= wdata_i[HGATE_W-1:0];
      if (pa_wr) pgate0_o <= wdata_i[PGATE0_W-1:0] & PGATE0_MASK[PGATE0_W-1:0];
      if (pb_wr) pgate1_o <= wdata_i[PGATE1_W-1:0] & PGATE1_MASK;
      if (lp_wr) begin
        if (src_code_valid(int'(wdata_i[F_SRC_LO +: 3])))
          lp_src_o <= wdata_i[F_SRC_LO +: 3];
        lp_en_o <= wdata_i[F_LPEN];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      ADDR_W'(RA_CTRL): begin
        rd_next[F_SRC_LO +: 3]      = cfg_o.src;
        rd_next[F_HDIV_LO +: DIV_W] = cfg_o.hdiv;
        rd_next[F_PDIV]             = cfg_o.pdiv;
        rd_next[F_EDGE]             = cfg_o.edge_rise;
        rd_next[F_BUSY]             = busy_o;
      end
      ADDR_W'(RA_HGATE):  rd_next[HGATE_W-1:0]  = hgate_o;
      ADDR_W'(RA_PGATEA): rd_next[PGATE0_W-1:0] = pgate0_o;
      ADDR_W'(RA_PGATEB): rd_next[PGATE1_W-1:0] = pgate1_o;
      ADDR_W'(RA_LOWPWR): begin
        rd_next[F_SRC_LO +: 3] = lp_src_o;
        rd_next[F_LPEN]        = lp_en_o;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

endmodule

// File: rtl/tick_ctrl_src.sv
module tick_ctrl_src
  import tick_ctrl_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               edge_rise_i,
  input  logic [SEL_W-1:0]   ahb_sel_i,
  input  logic [SEL_W-1:0]   lp_sel_i,
  output logic               ahb_src_tick_o,
  output logic               lp_src_tick_o
);

  localparam int NCODE = 1 << SEL_W;

  logic             ext_q;
  logic             ext_rise, ext_fall, ext_tick;
  logic [NCODE-1:0] by_code;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= src_i[EXT_IDX];
  end

  assign ext_rise = src_i[EXT_IDX] & ~ext_q;
  assign ext_fall = ~src_i[EXT_IDX] & ext_q;
  assign ext_tick = ext_rise | (ext_fall & ~edge_rise_i);

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    if (!src_code_valid(c) || code_to_idx(c) >= NUM_SRC) begin : g_none
      assign by_code[c] = 1'b0;
    end else if (c == EXT_IDX) begin : g_ext
      assign by_code[c] = ext_tick;
    end else begin : g_plain
      assign by_code[c] = src_i[code_to_idx(c)];
    end
  end

  assign ahb_src_tick_o = by_code[ahb_sel_i];
  assign lp_src_tick_o  = by_code[lp_sel_i];

endmodule

// File: rtl/tick_ctrl_div.sv
module tick_ctrl_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_tick_i,
  input  logic [DIV_W-1:0] hdiv_i,
  input  logic             pdiv_i,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic             ahb_fire_o,
  output logic             apb_fire_o
);

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             phase;
  logic             at_lim;

  assign lim    = {CNT_W{1'b1}} >> (CNT_W - int'(hdiv_i));
  assign at_lim = (cnt == lim);

  assign ahb_fire_o = src_tick_i && !hold_i && !restart_i && at_lim;
  assign apb_fire_o = ahb_fire_o && (!pdiv_i || phase);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!hold_i && src_tick_i) begin
      if (at_lim) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_ctrl_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 3,
  parameter int          SEL_W       = 3,
  parameter int          DIV_W       = 3,
  parameter int          HGATE_W     = 4,
  parameter int          PGATE0_W    = 32,
  parameter int          PGATE1_W    = 3,
  parameter int          BUSY_CYCLES = 4,
  parameter logic [3:0]  HGATE_RST   = 4'b0101,
  parameter logic [31:0] PGATE0_MASK = 32'h6FFF_FFFF,
  parameter logic [2:0]  PGATE1_MASK = 3'b111,
  parameter logic [2:0]  PGATE1_RST  = 3'b010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                lp_mode_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                busy_o,
  output logic                ahb_tick_o,
  output logic                apb_tick_o,
  output logic                core_tick_o,
  output logic [HGATE_W-1:0]  ahb_en_o,
  output logic [PGATE0_W-1:0] apb_en0_o,
  output logic [PGATE1_W-1:0] apb_en1_o
);

  ctrl_cfg_t           cfg;
  logic [2:0]          lp_src;
  logic                lp_en;
  logic [HGATE_W-1:0]  hgate;
  logic [PGATE0_W-1:0] pgate0;
  logic [PGATE1_W-1:0] pgate1;
  logic                busy, restart;
  logic                ahb_src_tick, lp_src_tick;
  logic                ahb_fire, apb_fire;

  tick_ctrl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
    .HGATE_W(HGATE_W), .PGATE0_W(PGATE0_W), .PGATE1_W(PGATE1_W),
    .BUSY_CYCLES(BUSY_CYCLES), .HGATE_RST(HGATE_RST),
    .PGATE0_MASK(PGATE0_MASK), .PGATE1_MASK(PGATE1_MASK),
    .PGATE1_RST(PGATE1_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_o(cfg),
    .lp_src_o(lp_src), .lp_en_o(lp_en), .hgate_o(hgate),
    .pgate0_o(pgate0), .pgate1_o(pgate1), .busy_o(busy),
    .restart_o(restart)
  );

  tick_ctrl_src #(.SEL_W(SEL_W)) src_sel_i (
    .clk(clk), .rst(rst), .src_i(src_i), .edge_rise_i(cfg.edge_rise),
    .ahb_sel_i(cfg.src), .lp_sel_i(lp_src),
    .ahb_src_tick_o(ahb_src_tick), .lp_src_tick_o(lp_src_tick)
  );

  tick_ctrl_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .src_tick_i(ahb_src_tick), .hdiv_i(cfg.hdiv),
    .pdiv_i(cfg.pdiv), .restart_i(restart), .hold_i(busy),
    .ahb_fire_o(ahb_fire), .apb_fire_o(apb_fire)
  );

  assign busy_o = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ahb_tick_o  <= 1'b0;
      apb_tick_o  <= 1'b0;
      core_tick_o <= 1'b0;
      ahb_en_o    <= '0;
      apb_en0_o   <= '0;
      apb_en1_o   <= '0;
    end else begin
      ahb_tick_o  <= ahb_fire;
      apb_tick_o  <= apb_fire;
      core_tick_o <= lp_mode_i ? (lp_en & lp_src_tick) : ahb_fire;
      ahb_en_o    <= hgate  & {HGATE_W{ahb_fire}};
      apb_en0_o   <= pgate0 & {PGATE0_W{apb_fire}};
      apb_en1_o   <= pgate1 & {PGATE1_W{apb_fire}};
    end
  end

endmodule

// File: rtl/tick_ctrl_chk.sv
module tick_ctrl_chk #(
  parameter int          ADDR_W      = 3,
  parameter int          HGATE_W     = 4,
  parameter int          PGATE0_W    = 32,
  parameter int          PGATE1_W    = 3,
  parameter logic [31:0] PGATE0_MASK = 32'h6FFF_FFFF
) (
  input logic                clk,
  input logic                rst,
  input logic                busy_o,
  input logic                ahb_tick_o,
  input logic                apb_tick_o,
  input logic                core_tick_o,
  input logic [HGATE_W-1:0]  ahb_en_o,
  input logic [PGATE0_W-1:0] apb_en0_o,
  input logic [PGATE1_W-1:0] apb_en1_o,
  input logic                lp_mode_i,
  input logic                lp_en,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i
);

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!ahb_tick_o && !apb_tick_o));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we_i && reg_addr_i == ADDR_W'(0) && !busy_o) |=> busy_o);

  // R5
  apb_in_ahb_chk: assert property (@(posedge clk) disable iff (rst)
    apb_tick_o |-> ahb_tick_o);

  // R9
  hgate_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (|ahb_en_o) |-> ahb_tick_o);

  // R9
  pgate_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ((|apb_en0_o) || (|apb_en1_o)) |-> apb_tick_o);

  // R9
  pgate_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (apb_en0_o & ~PGATE0_MASK[PGATE0_W-1:0]) == '0);

  // R10
  lp_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_mode_i && !lp_en) |=> !core_tick_o);

endmodule

bind tick_ctrl tick_ctrl_chk #(
  .ADDR_W(ADDR_W), .HGATE_W(HGATE_W), .PGATE0_W(PGATE0_W),
  .PGATE1_W(PGATE1_W), .PGATE0_MASK(PGATE0_MASK)
) chk_i (
  .clk(clk), .rst(rst), .busy_o(busy_o), .ahb_tick_o(ahb_tick_o),
  .apb_tick_o(apb_tick_o), .core_tick_o(core_tick_o), .ahb_en_o(ahb_en_o),
  .apb_en0_o(apb_en0_o), .apb_en1_o(apb_en1_o), .lp_mode_i(lp_mode_i),
  .lp_en(lp_en), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i)
);

// File: tb/tick_ctrl_tb_top.sv
module tick_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  src_base;
  logic        ext_lvl;
  logic        ext_run;
  logic [1:0]  ext_ph;
  logic        lp_mode;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        busy, ahb_t, apb_t, core_t;
  logic [3:0]  ahb_en;
  logic [31:0] apb_en0;
  logic [2:0]  apb_en1;
  logic [5:0]  src_w;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign src_w = {src_base[5:4], ext_lvl, src_base[2:0]};

  always @(negedge clk) begin
    if (!ext_run) begin
      ext_ph  <= 2'd0;
      ext_lvl <= 1'b0;
    end else begin
      ext_ph <= ext_ph + 2'd1;
      if (ext_ph[0]) ext_lvl <= ~ext_lvl;
    end
  end

  tick_ctrl dut_i (
    .clk(clk), .rst(rst), .src_i(src_w), .lp_mode_i(lp_mode),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .busy_o(busy), .ahb_tick_o(ahb_t),
    .apb_tick_o(apb_t), .core_tick_o(core_t), .ahb_en_o(ahb_en),
    .apb_en0_o(apb_en0), .apb_en1_o(apb_en1)
  );

  function automatic logic [31:0] ctrl_word(input int code, input int n,
                                            input bit p, input bit e);
    return (32'(code) & 32'h7) | ((32'(n) & 32'h7) << 8) |
           (32'(p) << 16) | (32'(e) << 28);
  endfunction

  function automatic int code_idx(input int code);
    return (code < 4) ? code : code - 1;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cfg(input int code, input int n, input bit p, input bit e);
    wr(3'd0, ctrl_word(code, n, p, e));
    wait_idle();
  endtask

  task automatic tally(input int len, output int na, output int np, output int nc);
    na = 0; np = 0; nc = 0;
    repeat (len) begin
      @(negedge clk);
      if (ahb_t)  na++;
      if (apb_t)  np++;
      if (core_t) nc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int na, np, nc, len;
    int codes[5] = '{0, 1, 2, 5, 6};
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; src_base = '0; ext_run = 1'b0; lp_mode = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!ahb_t && !apb_t && !core_t && ahb_en == 0 && apb_en0 == 0 && apb_en1 == 0 && !busy,
        "R1 outputs low", {ahb_t, apb_t, core_t, busy}, 0);
    rd(3'd0, d); chk(d == 32'h0, "R1 control reset", d, 32'h0);
    rd(3'd1, d); chk(d == 32'h5, "R1 mem gate reset", d, 32'h5);
    rd(3'd2, d); chk(d == 32'h0, "R1 gate A reset", d, 32'h0);
    rd(3'd3, d); chk(d == 32'h2, "R1 gate B reset", d, 32'h2);
    rd(3'd4, d); chk(d == 32'h0, "R1 low-power reset", d, 32'h0);

    // R7 busy window length and readback
    wr(3'd0, ctrl_word(0, 0, 0, 0));
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    chk(len == 4, "R7 busy length", len, 4);
    wr(3'd0, ctrl_word(1, 0, 0, 0));
    rd(3'd0, d);
    chk(d[29] == 1'b1, "R7 busy bit during switch", d, 32'h2000_0001);
    wait_idle();

    // R8 writes during busy ignored except edge bit
    wr(3'd0, ctrl_word(2, 1, 0, 0));
    wr(3'd0, ctrl_word(5, 5, 1, 1));
    wait_idle();
    rd(3'd0, d);
    chk(d == ctrl_word(2, 1, 0, 1), "R8 busy-time write", d, ctrl_word(2, 1, 0, 1));

    // R3 reserved source codes
    cfg(4, 2, 0, 0);
    rd(3'd0, d);
    chk(d == ctrl_word(2, 2, 0, 0), "R3 code 4 ignored", d, ctrl_word(2, 2, 0, 0));
    cfg(7, 3, 0, 0);
    rd(3'd0, d);
    chk(d == ctrl_word(2, 3, 0, 0), "R3 code 7 ignored", d, ctrl_word(2, 3, 0, 0));

    // R2 R4 R5 random configurations
    for (int i = 0; i < 8; i++) begin
      int code, n;
      bit p;
      code = codes[$urandom % 5];
      n = $urandom % 5;
      p = bit'($urandom % 2);
      src_base = 6'(1 << code_idx(code));
      cfg(code, n, p, 0);
      tally(16 << n, na, np, nc);
      chk(na == 16, "R4 main tick count", na, 16);
      chk(np == (p ? 8 : 16), "R5 peripheral tick count", np, p ? 8 : 16);
      chk(nc == 16, "R10 core follows main tick", nc, 16);
      src_base = ~6'(1 << code_idx(code)) & 6'b110111;
      tally(32, na, np, nc);
      chk(na == 0, "R2 unselected sources silent", na, 0);
    end

    // R6 external edge modes
    src_base = '0;
    ext_run = 1'b1;
    cfg(3, 0, 0, 0);
    tally(64, na, np, nc);
    chk(na >= 31 && na <= 33, "R6 both edges", na, 32);
    cfg(3, 0, 0, 1);
    tally(64, na, np, nc);
    chk(na >= 15 && na <= 17, "R6 rising only", na, 16);
    ext_run = 1'b0;

    // R9 gates
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d);
    chk(d == 32'h6FFF_FFFF, "R9 gate A reserved bits", d, 32'h6FFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d);
    chk(d == 32'h7, "R9 gate B width", d, 32'h7);
    wr(3'd1, 32'h0000_000A);
    src_base = 6'b000001;
    cfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(apb_t && apb_en0 == 32'h6FFF_FFFF && apb_en1 == 3'h7 && ahb_en == 4'hA,
        "R9 enables with tick", apb_en0, 32'h6FFF_FFFF);
    wr(3'd2, 32'h0000_0005);
    @(negedge clk);
    chk(apb_en0 == 32'h5, "R9 narrowed gate", apb_en0, 32'h5);
    cfg(0, 0, 1, 0);
    len = 0;
    while (!(ahb_t && !apb_t) && len < 6) begin len++; @(negedge clk); end
    chk(ahb_en == 4'hA && apb_en0 == 0 && apb_en1 == 0,
        "R9 no peripheral enable without its tick", apb_en0, 0);

    // R10 low-power core tick
    src_base = 6'b000001;
    cfg(2, 0, 0, 0);
    wr(3'd4, 32'h0001_0000);
    lp_mode = 1'b1;
    @(negedge clk);
    tally(32, na, np, nc);
    chk(nc == 32, "R10 core runs from low-power source", nc, 32);
    chk(na == 0, "R10 main tick on other source", na, 0);
    wr(3'd4, 32'h0000_0000);
    @(negedge clk);
    tally(32, na, np, nc);
    chk(nc == 0, "R10 core stopped", nc, 0);
    src_base = 6'b010000;
    wr(3'd4, 32'h0001_0005);
    @(negedge clk);
    tally(32, na, np, nc);
    chk(nc == 32, "R10 core from code 5", nc, 32);
    wr(3'd4, 32'h0001_0007);
    rd(3'd4, d);
    chk(d == 32'h0001_0005, "R3 low-power reserved code", d, 32'h0001_0005);

    // R11 read latency: data follows the address one cycle later
    @(negedge clk); addr = 3'd3;
    @(negedge clk);
    chk(rdata == 32'h7, "R11 read latency", rdata, 32'h7);
    lp_mode = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule